// File: doc/BRIEF.md
# Oscillator Tuning-Word Acquisition Controller

This block drives the tuning word of a digitally controlled oscillator inside an all-digital PLL. It runs once per reference clock cycle. It starts with a coarse calibration search. It then moves on to a frequency acquisition phase with adaptive steps. Once it is locked, it applies single-unit tracking corrections.

Each cycle the phase/frequency detector supplies a fast/slow decision and a coarse error magnitude. The decision selects the direction of the correction: when the oscillator is fast, the word goes down. During acquisition the magnitude selects a new step size, and that step is averaged with the previous step. Large errors therefore move the word quickly, and the step shrinks smoothly as the error falls.

Lock is declared when the decision flips twice in a row at a step of one unit, or when the acquisition cycle budget is used up. The detector inputs are plain per-cycle levels sampled on every rising edge. They have no handshake, and the controller can never apply back-pressure to the detector. A start pulse restarts the sequence from any phase.

Top module: `dco_acq_ctrl`

## Requirements
- R1: While reset is held, and at the first check after reset, the tuning word is 512 (mid-scale), the phase output is 0 (calibration) and locked is 0.
- R2: The phase output takes only the codes 0 (calibration), 1 (acquisition) and 2 (tracking), never 3. It advances only in the order 0, 1, 2. Locked is 1 exactly when the phase is 2.
- R3: Calibration lasts 4 cycles and resolves tuning-word bits 9 down to 6, one bit per cycle. In each cycle the trial bit is cleared if fast_i is 1, and the next lower bit of the four is set as the new trial. Bits 5..0 stay 0, err_mag_i has no effect, and the phase becomes 1 after the 4th cycle.
- R4: In acquisition, err_mag_i maps to a new step: 3 gives 64, 2 gives 16, 1 gives 4 and 0 gives 0. The applied step is floor((previous step + new step)/2), raised to 1 if it would be 0. The previous step is 64 on entry to acquisition. The word decreases by the step when fast_i is 1 and increases by it otherwise.
- R5: A reversal is an acquisition cycle whose fast_i differs from fast_i in the previous acquisition cycle. The first acquisition cycle is never a reversal. When two consecutive acquisition cycles are both reversals with an applied step of 1, the phase is 2 after that edge.
- R6: Acquisition never lasts more than 18 cycles. If lock has not been reached, the phase is 2 after the 18th acquisition edge.
- R7: In tracking, the word decreases by 1 when fast_i is 1 and increases by 1 otherwise. err_mag_i has no effect.
- R8: The tuning word saturates at 0 and at 1023 in every phase and never wraps.
- R9: A start_i pulse, in any phase, takes priority over all other inputs. After that edge the word is 512, the phase is 0 and locked is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; one update per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Restart pulse, returns to calibration |
| fast_i | input | 1 | Detector decision: 1 when the oscillator is fast |
| err_mag_i | input | 2 | Error magnitude class: 0 none, 1 small, 2 medium, 3 large |
| tune_word_o | output | 10 | Oscillator tuning word |
| phase_o | output | 2 | Current phase: 0 calibration, 1 acquisition, 2 tracking |
| locked_o | output | 1 | High while tracking |

## Verification
The hardest situation to create is lock by reversals. It needs the adaptive step to shrink all the way to one unit, followed by two alternating detector decisions in a row, and all of this must fit inside the 18-cycle budget. The stimulus gets there by driving falling error classes, then magnitude 0 with an alternating fast/slow pattern, so the averaged step halves down to 1 within about eight cycles. A separate run keeps the magnitude large and the direction fixed. That run pins the word at full scale and exhausts the budget, so the timeout path to tracking and the upper saturation are both exercised. An all-fast run does the same for the lower bound.

// File: rtl/dco_acq_pkg.sv
package dco_acq_pkg;
  typedef enum logic [1:0] {
    PH_CAL = 2'd0,
    PH_ACQ = 2'd1,
    PH_TRK = 2'd2
  } phase_e;
endpackage

// File: rtl/dco_sat_adj.sv
// Saturating add/subtract of a magnitude to the tuning word.
module dco_sat_adj #(
  parameter int W = 10
) (
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] mag_i,
  input  logic         down_i,
  output logic [W-1:0] word_o
);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, word_i} + {1'b0, mag_i};
    if (down_i) begin
      word_o = (mag_i > word_i) ? '0 : (word_i - mag_i);
    end else begin
      word_o = sum[W] ? '1 : sum[W-1:0];
    end
  end
endmodule

// File: rtl/dco_cal_search.sv
// One bit of the successive-approximation search over the top CAL_BITS bits.
module dco_cal_search #(
  parameter int W        = 10,
  parameter int CAL_BITS = 4,
  localparam int CIW     = (CAL_BITS > 1) ? $clog2(CAL_BITS) : 1
) (
  input  logic [W-1:0]   word_i,
  input  logic [CIW-1:0] idx_i,
  input  logic           fast_i,
  output logic [W-1:0]   word_o,
  output logic           last_o
);
  int trial_pos;

  always_comb begin
    trial_pos = W - 1 - int'(idx_i);
    last_o    = (idx_i == CIW'(CAL_BITS - 1));
    word_o    = word_i;
    for (int b = 0; b < W; b++) begin
      if (b == trial_pos && fast_i) begin
        word_o[b] = 1'b0;
      end
      if (b == trial_pos - 1 && !last_o) begin
        word_o[b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dco_acq_step.sv
// Adaptive step: mean of previous step and the magnitude-selected step, floor 1.
module dco_acq_step #(
  parameter int W          = 10,
  parameter int STEP_LARGE = 64,
  parameter int STEP_MED   = 16,
  parameter int STEP_SMALL = 4
) (
  input  logic [1:0]   mag_i,
  input  logic [W-1:0] prev_i,
  output logic [W-1:0] step_o
);
  logic [W-1:0] fresh;
  logic [W:0]   total;
  logic [W-1:0] half;

  always_comb begin
    case (mag_i)
      2'd3:    fresh = W'(STEP_LARGE);
      2'd2:    fresh = W'(STEP_MED);
      2'd1:    fresh = W'(STEP_SMALL);
      default: fresh = '0;
    endcase
    total  = {1'b0, prev_i} + {1'b0, fresh};
    half   = total[W:1];
    step_o = (half == '0) ? W'(1) : half;
  end
endmodule

// File: rtl/dco_acq_ctrl.sv
module dco_acq_ctrl #(
  parameter int W          = 10,
  parameter int CAL_BITS   = 4,
  parameter int ACQ_BUDGET = 18,
  parameter int LOCK_REVS  = 2,
  parameter int STEP_LARGE = 64,
  parameter int STEP_MED   = 16,
  parameter int STEP_SMALL = 4,
  parameter int STEP_INIT  = 64
) (
  input  logic         clk_ref,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         fast_i,
  input  logic [1:0]   err_mag_i,
  output logic [W-1:0] tune_word_o,
  output logic [1:0]   phase_o,
  output logic         locked_o
);
  import dco_acq_pkg::*;

  localparam int CIW = (CAL_BITS > 1) ? $clog2(CAL_BITS) : 1;
  localparam int AW  = $clog2(ACQ_BUDGET + 1);
  localparam int RW  = $clog2(LOCK_REVS + 1);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  phase_e         phase_q;
  logic [W-1:0]   word_q;
  logic [CIW-1:0] cal_idx_q;
  logic [W-1:0]   step_q;
  logic           prev_fast_q;
  logic           prev_valid_q;
  logic [RW-1:0]  rev_cnt_q;
  logic [AW-1:0]  acq_cnt_q;
  logic           locked_q;

  logic [W-1:0]   cal_word;
  logic           cal_last;
  logic [W-1:0]   step_n;
  logic [W-1:0]   adj_mag;
  logic [W-1:0]   adj_word;
  logic           reversal;
  logic [RW-1:0]  rev_next;
  logic           lock_hit;
  logic           budget_hit;

  dco_cal_search #(.W(W), .CAL_BITS(CAL_BITS)) u_cal (
    .word_i (word_q),
    .idx_i  (cal_idx_q),
    .fast_i (fast_i),
    .word_o (cal_word),
    .last_o (cal_last)
  );

  dco_acq_step #(
    .W(W), .STEP_LARGE(STEP_LARGE), .STEP_MED(STEP_MED), .STEP_SMALL(STEP_SMALL)
  ) u_step (
    .mag_i  (err_mag_i),
    .prev_i (step_q),
    .step_o (step_n)
  );

  assign adj_mag = (phase_q == PH_ACQ) ? step_n : W'(1);

  dco_sat_adj #(.W(W)) u_adj (
    .word_i (word_q),
    .mag_i  (adj_mag),
    .down_i (fast_i),
    .word_o (adj_word)
  );

  always_comb begin
    reversal   = prev_valid_q && (fast_i != prev_fast_q);
    rev_next   = (reversal && step_n == W'(1)) ? rev_cnt_q + RW'(1) : '0;
    lock_hit   = (rev_next == RW'(LOCK_REVS));
    budget_hit = (acq_cnt_q == AW'(ACQ_BUDGET - 1));
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_CAL;
      word_q       <= MID;
      cal_idx_q    <= '0;
      step_q       <= W'(STEP_INIT);
      prev_fast_q  <= 1'b0;
      prev_valid_q <= 1'b0;
      rev_cnt_q    <= '0;
      acq_cnt_q    <= '0;
      locked_q     <= 1'b0;
    end else if (start_i) begin
      phase_q      <= PH_CAL;
      word_q       <= MID;
      cal_idx_q    <= '0;
      step_q       <= W'(STEP_INIT);
      prev_fast_q  <= 1'b0;
      prev_valid_q <= 1'b0;
      rev_cnt_q    <= '0;
      acq_cnt_q    <= '0;
      locked_q     <= 1'b0;
    end else begin
      case (phase_q)
        PH_CAL: begin
          word_q    <= cal_word;
          cal_idx_q <= cal_idx_q + CIW'(1);
          if (cal_last) begin
            phase_q      <= PH_ACQ;
            step_q       <= W'(STEP_INIT);
            prev_valid_q <= 1'b0;
            rev_cnt_q    <= '0;
            acq_cnt_q    <= '0;
          end
        end
        PH_ACQ: begin
          word_q       <= adj_word;
          step_q       <= step_n;
          prev_fast_q  <= fast_i;
          prev_valid_q <= 1'b1;
          rev_cnt_q    <= rev_next;
          acq_cnt_q    <= acq_cnt_q + AW'(1);
          if (lock_hit || budget_hit) begin
            phase_q  <= PH_TRK;
            locked_q <= 1'b1;
          end
        end
        PH_TRK: begin
          word_q <= adj_word;
        end
        default: begin
          phase_q <= PH_CAL;
          word_q  <= MID;
        end
      endcase
    end
  end

  assign tune_word_o = word_q;
  assign phase_o     = phase_q;
  assign locked_o    = locked_q;
endmodule

// File: rtl/dco_acq_ctrl_chk.sv
module dco_acq_ctrl_chk #(
  parameter int W          = 10,
  parameter int ACQ_BUDGET = 18
) (
  input logic         clk_ref,
  input logic         rst_n,
  input logic         start_i,
  input logic         fast_i,
  input logic [W-1:0] tune_word_o,
  input logic [1:0]   phase_o,
  input logic         locked_o
);
  localparam int CW = $clog2(ACQ_BUDGET + 1) + 1;
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  logic [CW-1:0] acq_seen;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) acq_seen <= '0;
    else if (phase_o == 2'd1) acq_seen <= acq_seen + CW'(1);
    else acq_seen <= '0;
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk_ref) disable iff (!rst_n) phase_o != 2'd3); // R2
  AST_LOCK_PHASE: assert property (@(posedge clk_ref) disable iff (!rst_n) locked_o == (phase_o == 2'd2)); // R2
  AST_NO_BACKSTEP: assert property (@(posedge clk_ref) disable iff (!rst_n) (!start_i && phase_o != 2'd0) |=> phase_o != 2'd0); // R2
  AST_ACQ_BUDGET: assert property (@(posedge clk_ref) disable iff (!rst_n) (phase_o == 2'd1) |-> (acq_seen < CW'(ACQ_BUDGET))); // R6
  AST_TRK_UNIT: assert property (@(posedge clk_ref) disable iff (!rst_n) (phase_o == 2'd2 && !start_i) |=> (({1'b0, tune_word_o} + 1'b1) >= {1'b0, $past(tune_word_o)}) && ({1'b0, tune_word_o} <= ({1'b0, $past(tune_word_o)} + 1'b1))); // R7
  AST_TRK_DOWN: assert property (@(posedge clk_ref) disable iff (!rst_n) (phase_o == 2'd2 && !start_i && fast_i && tune_word_o != '0) |=> tune_word_o == $past(tune_word_o) - W'(1)); // R7
  AST_START_MID: assert property (@(posedge clk_ref) disable iff (!rst_n) start_i |=> (tune_word_o == MID && phase_o == 2'd0 && !locked_o)); // R9
endmodule

bind dco_acq_ctrl dco_acq_ctrl_chk #(.W(W), .ACQ_BUDGET(ACQ_BUDGET)) u_chk (
  .clk_ref     (clk_ref),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .fast_i      (fast_i),
  .tune_word_o (tune_word_o),
  .phase_o     (phase_o),
  .locked_o    (locked_o)
);

// File: tb/tb_dco_acq_ctrl.sv
module tb_dco_acq_ctrl;
  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       fast_i = 1'b0;
  logic [1:0] err_mag_i = 2'd0;
  logic [9:0] tune_word_o;
  logic [1:0] phase_o;
  logic       locked_o;

  int checks = 0;
  int errors = 0;

  logic [12:0] exp_q[$];
  string       tag_q[$];

  // reference model state
  int m_word, m_phase, m_k, m_step, m_revs, m_acq;
  bit m_pf, m_pv;

  dco_acq_ctrl dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .start_i(start_i), .fast_i(fast_i),
    .err_mag_i(err_mag_i), .tune_word_o(tune_word_o), .phase_o(phase_o),
    .locked_o(locked_o)
  );

  always #5 clk_ref = ~clk_ref;

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual word=%0d phase=%0d locked=%0d expected word=%0d phase=%0d locked=%0d",
               tag, act[9:0], act[11:10], act[12], exp[9:0], exp[11:10], exp[12]);
    end
  endtask

  task automatic model_restart();
    m_word = 512; m_phase = 0; m_k = 0; m_step = 64;
    m_revs = 0; m_acq = 0; m_pf = 0; m_pv = 0;
  endtask

  task automatic model_step(input bit f, input int mag, input bit s);
    int fresh, st;
    bit rev;
    if (s) begin
      model_restart();
    end else if (m_phase == 0) begin
      if (f) m_word = m_word & ~(1 << (9 - m_k));
      if (m_k < 3) m_word = m_word | (1 << (8 - m_k));
      m_k++;
      if (m_k == 4) begin
        m_phase = 1; m_step = 64; m_pv = 0; m_revs = 0; m_acq = 0;
      end
    end else if (m_phase == 1) begin
      fresh = (mag == 3) ? 64 : (mag == 2) ? 16 : (mag == 1) ? 4 : 0;
      st = (m_step + fresh) / 2;
      if (st == 0) st = 1;
      m_word = f ? ((m_word - st < 0) ? 0 : m_word - st)
                 : ((m_word + st > 1023) ? 1023 : m_word + st);
      rev = m_pv && (f != m_pf);
      m_revs = (rev && st == 1) ? m_revs + 1 : 0;
      m_pf = f; m_pv = 1; m_step = st; m_acq++;
      if (m_revs == 2 || m_acq == 18) m_phase = 2;
    end else begin
      m_word = f ? ((m_word == 0) ? 0 : m_word - 1)
                 : ((m_word == 1023) ? 1023 : m_word + 1);
    end
  endtask

  function automatic logic [12:0] model_out();
    return {(m_phase == 2) ? 1'b1 : 1'b0, 2'(m_phase), 10'(m_word)};
  endfunction

  // driver: applies one cycle of stimulus and queues the expectation
  task automatic drive(input bit f, input int mag, input bit s, input string tag);
    fast_i = f; err_mag_i = 2'(mag); start_i = s;
    model_step(f, mag, s);
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
    @(negedge clk_ref);
  endtask

  // monitor: compares two time units after each rising edge
  always begin
    @(posedge clk_ref);
    #2;
    if (exp_q.size() > 0) begin
      check(tag_q.pop_front(), {locked_o, phase_o, tune_word_o}, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL R6: watchdog expired, actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_restart();
    repeat (3) @(negedge clk_ref);
    check("R1 reset state", {locked_o, phase_o, tune_word_o}, {1'b0, 2'd0, 10'd512});
    rst_n = 1'b1;

    // R3: calibration with alternating decisions, magnitude varied (ignored)
    drive(1, 3, 0, "R3 cal bit9");
    drive(0, 0, 0, "R3 cal bit8");
    drive(1, 2, 0, "R3 cal bit7");
    drive(0, 1, 0, "R3 cal bit6 to acq R2");
    // R4: adaptive steps from falling error classes
    drive(0, 3, 0, "R4 step 64 up");
    drive(0, 2, 0, "R4 step 40 up");
    drive(1, 1, 0, "R4 step 22 down");
    drive(0, 0, 0, "R4 step 11 up");
    drive(1, 0, 0, "R4 step 5 down");
    drive(0, 0, 0, "R4 step 2 up");
    // R5: two reversals at unit step
    drive(1, 0, 0, "R5 first unit reversal");
    drive(0, 0, 0, "R5 second unit reversal locks");
    // R7: tracking, magnitude ignored
    drive(1, 3, 0, "R7 track down");
    drive(1, 2, 0, "R7 track down");
    drive(0, 3, 0, "R7 track up");
    drive(0, 0, 0, "R7 track up");
    // R9: restart from tracking
    drive(1, 3, 1, "R9 start from tracking");
    drive(0, 0, 0, "R3 cal after restart");
    drive(1, 0, 0, "R3 cal after restart");
    drive(1, 3, 1, "R9 start mid calibration");
    // R8 and R6: all slow, large magnitude -> pins at 1023, budget runs out
    for (int i = 0; i < 4; i++) drive(0, 3, 0, "R3 cal all slow");
    for (int i = 0; i < 18; i++) drive(0, 3, 0, "R8 R6 upper saturation in acq");
    for (int i = 0; i < 3; i++) drive(0, 1, 0, "R8 upper saturation in track");
    drive(1, 0, 0, "R7 track down from top");
    // R9 during acquisition, then lower bound
    drive(0, 0, 1, "R9 start");
    for (int i = 0; i < 4; i++) drive(1, 0, 0, "R3 cal all fast");
    drive(1, 3, 0, "R8 acq lower saturation");
    drive(1, 2, 1, "R9 start mid acquisition");
    for (int i = 0; i < 4; i++) drive(1, 1, 0, "R3 cal all fast again");
    for (int i = 0; i < 18; i++) drive(1, 3, 0, "R8 R6 lower saturation in acq");
    for (int i = 0; i < 3; i++) drive(1, 2, 0, "R8 lower saturation in track");
    drive(0, 0, 0, "R7 track up from bottom");
    repeat (3) @(negedge clk_ref);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule